// File: doc/BRIEF.md
# Load-Align Shift Merge Unit

This unit forms the new value of a 64-bit destination register for loads that stream data into the top of that register. Each accepted load takes the register's current contents and one byte or one halfword picked out of the memory read word. The old contents move down by the access size, and the new item fills the vacated top lane. Repeated loads therefore gather an unaligned stream in the register, with the oldest item ending up at the bottom.

The surrounding pipeline presents a strobe together with a size select, the low address bits, the old register value and the memory read word. One cycle later the merged value appears with its own valid flag. The merge does not depend on how the address was generated, so every addressing mode of the load shares this unit. Address generation, the memory and the register file sit outside the block.

Top module: `load_align_merge`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `res_valid` is 0 and `res_data` is all zeros.
- R2: A byte access (`ld_half` = 0) produces a result whose bits 55:0 equal bits 63:8 of the old value and whose bits 63:56 hold the selected byte.
- R3: A halfword access (`ld_half` = 1) produces a result whose bits 47:0 equal bits 63:16 of the old value and whose bits 63:48 hold the selected halfword.
- R4: For a byte access, the selected byte is read-word bits 8k+7:8k, where k is the value on `ld_addr` (little-endian lanes, k = 0 to 7).
- R5: For a halfword access, bit 0 of `ld_addr` is ignored. With j = `ld_addr` with bit 0 cleared, read-word byte j becomes result bits 55:48 and byte j+1 becomes result bits 63:56.
- R6: `res_valid` is high on exactly the cycle after each cycle in which `ld_valid` is high. This holds for back-to-back strobes as well.
- R7: In a cycle that follows one without `ld_valid`, `res_valid` is low and `res_data` keeps its previous value.
- R8: Starting from an all-ones register, four byte accesses to addresses 0 to 3 of a read word holding bytes 01 to 08 (byte 0 = 01) leave 0x04030201FFFFFFFF when each result is fed back as the next old value.
- R9: From the same start and with the same read word, four halfword accesses to addresses 0, 2, 4 and 6, chained the same way, leave 0x0807060504030201.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load item is presented this cycle |
| ld_half | input | 1 | Access size: 0 = byte, 1 = halfword |
| ld_addr | input | 3 | Low address bits that pick the lane in the read word |
| ld_old | input | 64 | Current destination register value |
| ld_rdata | input | 64 | Memory read word |
| res_valid | output | 1 | Merged result is valid this cycle |
| res_data | output | 64 | Merged destination value |

## Verification
Every merged value is due exactly one clock after the cycle that carries its strobe, because a single register stage lies between the inputs and the outputs. The driver changes the inputs on falling edges and queues the expected value for each strobe it sends. The monitor looks at the outputs on the next falling edge, half a period after the capturing rising edge. It removes one queued item for every cycle in which `res_valid` is high, and on idle cycles it checks that the data holds its last value. Chained sequences take each expected result from the bench's own model as the next old value, so they check the full accumulation and do not depend on values read back from the design.

// File: rtl/load_align_merge.sv
module load_align_merge #(
  parameter int REG_W  = 64,
  parameter int WORD_W = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic                         ld_half,
  input  logic [$clog2(WORD_W/8)-1:0]  ld_addr,
  input  logic [REG_W-1:0]             ld_old,
  input  logic [WORD_W-1:0]            ld_rdata,
  output logic                         res_valid,
  output logic [REG_W-1:0]             res_data
);
  localparam int LANES = WORD_W / 8;
  localparam int AW    = $clog2(LANES);

  logic [AW+2:0]    byte_pos;
  logic [AW+2:0]    half_pos;
  logic [7:0]       item_b;
  logic [15:0]      item_h;
  logic [REG_W-1:0] merged;

  assign byte_pos = {ld_addr, 3'b000};
  assign half_pos = {ld_addr[AW-1:1], 4'b0000};
  assign item_b   = ld_rdata[byte_pos +: 8];
  assign item_h   = ld_rdata[half_pos +: 16];
  assign merged   = ld_half ? {item_h, ld_old[REG_W-1:16]}
                            : {item_b, ld_old[REG_W-1:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= ld_valid;
      if (ld_valid) res_data <= merged;
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (!res_valid && $stable(res_data)));

  assert_byte_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_half) |=> res_data[REG_W-9:0] == $past(ld_old[REG_W-1:8]));

  assert_half_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_half) |=> res_data[REG_W-17:0] == $past(ld_old[REG_W-1:16]));
endmodule

// File: tb/load_align_merge_tb.sv
`timescale 1ns/1ps
module load_align_merge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_half = 1'b0;
  logic [2:0]  ld_addr = '0;
  logic [63:0] ld_old = '0;
  logic [63:0] ld_rdata = '0;
  logic        res_valid;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  logic        mon_on = 1'b0;
  logic [63:0] last_exp = '0;
  logic [63:0] mreg;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  load_align_merge u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_half(ld_half),
    .ld_addr(ld_addr), .ld_old(ld_old), .ld_rdata(ld_rdata),
    .res_valid(res_valid), .res_data(res_data));

  function automatic logic [63:0] model(bit half, int addr, logic [63:0] old, logic [63:0] word);
    logic [63:0] b, h;
    b = (word >> (addr * 8)) & 64'hFF;
    h = (word >> ((addr & 6) * 8)) & 64'hFFFF;
    if (half) return (old >> 16) | (h << 48);
    return (old >> 8) | (b << 56);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(bit half, int addr, logic [63:0] old, logic [63:0] word, string tag);
    item_t it;
    @(negedge clk);
    ld_valid = 1'b1; ld_half = half; ld_addr = 3'(addr);
    ld_old = old; ld_rdata = word;
    it.exp = model(half, addr, old, word);
    it.tag = tag;
    sb.push_back(it);
    mreg = it.exp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_valid = 1'b0;
      ld_old = ~ld_old; ld_rdata = ~ld_rdata; ld_half = ~ld_half;
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check("R6 unexpected valid", 64'd1, 64'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(it.tag, res_data, it.exp);
          last_exp = it.exp;
        end
      end else begin
        check("R7 hold", res_data, last_exp);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, res_valid}, 64'd0);
        check("R1 data in reset", res_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {63'd0, res_valid}, 64'd0);
        check("R1 data after reset", res_data, 64'd0);
        mon_on = 1'b1;

        drive(0, 0, 64'h1122334455667788, 64'hA7A6A5A4A3A2A1A0, "R2 byte merge");
        idle(2);
        drive(1, 0, 64'h1122334455667788, 64'hA7A6A5A4A3A2A1A0, "R3 half merge");
        idle(1);
        for (int k = 0; k < 8; k++)
          drive(0, k, 64'hDEADBEEFCAFEF00D, 64'hF7E6D5C4B3A29180, "R4 byte lane");
        idle(2);
        for (int k = 0; k < 8; k++)
          drive(1, k, 64'h0123456789ABCDEF, 64'hF7E6D5C4B3A29180, "R5 half lane");
        idle(1);
        drive(1, 3, 64'h0, 64'h0807060504030201, "R5 odd address");
        idle(1);
        check("R5 odd address literal", res_data, 64'h0403000000000000);
        drive(0, 2, 64'hFFFF, 64'h55, "R6 back to back a");
        drive(1, 1, 64'h1234, 64'h9988, "R6 back to back b");
        idle(3);

        mreg = '1;
        for (int k = 0; k < 4; k++)
          drive(0, k, mreg, 64'h0807060504030201, "R8 byte chain");
        idle(2);
        check("R8 byte chain final", res_data, 64'h04030201FFFFFFFF);

        mreg = '1;
        for (int k = 0; k < 4; k++)
          drive(1, 2 * k, mreg, 64'h0807060504030201, "R9 half chain");
        idle(2);
        check("R9 half chain final", res_data, 64'h0807060504030201);
        check("R6 queue drained", 64'(sb.size()), 64'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 64'd1, 64'd0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule